// File: doc/BRIEF.md
# Seconds Base-Plus-Counter Timekeeper

This block keeps wall time as a count of seconds in an always-on clock domain. The time it reports is the sum of a stored 32-bit base and a free-running 32-bit seconds counter; both are unsigned and the sum wraps modulo 2^32. A tick divider turns `TICK_DIV` clock cycles into one second. Software reaches the block through a 16-bit register bus, where every 32-bit quantity is split into a low and a high half.

Writing a control bit does nothing by itself. Stores to the base or to the two software flag words, reads of them, the counter clear and the arming of a counter snapshot are all carried out on the cycle in which the `commit` pulse arrives; a handshake sequencer outside this block produces that pulse. To set the time, software commits three steps in order: load the base, clear the counter, then set flag 0 to 1 to mark the time valid.

The counter snapshot is a small two-state machine. SNAP_IDLE moves to SNAP_ARMED when a commit carries the arm request. SNAP_ARMED moves back to SNAP_IDLE when the trigger register is written with bit 0 set, and the running counter is latched into the snapshot registers on that same edge. In SNAP_IDLE a trigger write is ignored.

Top module: `rtc_base_counter_core`

## Requirements
- R1: After reset the base, the counter, both flags, the read-data halves, the snapshot halves and the control registers are all 0; a committed flag-0 read then returns 0, meaning the time is not yet valid.
- R2: The registers at 0x00 (control, all 16 bits), 0x04 (arm request, bit 0 only) and 0x10/0x14 (write data, low/high half) read back what was last written to them.
- R3: A commit while control bit 1 is set loads the base from the write data {0x14, 0x10}.
- R4: A commit while control bit 3 is set clears the counter and restarts the divider, so the next increment comes exactly `TICK_DIV` cycles after the commit edge.
- R5: Without a clear, the counter advances by exactly 1 once every `TICK_DIV` clock cycles.
- R6: `time_sec` equals base plus counter modulo 2^32, so a base of 0xFFFFFFFF with a counter of 1 gives 0.
- R7: A commit with control bit 5 (or bit 6) set stores the 32-bit write data into flag 0 (or flag 1).
- R8: A commit with a read bit set places a value in the read-data halves at 0x24 (low) and 0x28 (high). Bit 2 selects the base, bit 7 flag 0 and bit 8 flag 1, with priority base > flag 0 > flag 1. The value taken is the one held before that same commit's writes.
- R9: A commit with bit 0 of 0x04 set arms the snapshot. Writing 0x38 with bit 0 set while armed latches the counter into 0x30 (low) and 0x34 (high) and disarms. The same write while not armed leaves the snapshot unchanged.
- R10: The read-only offsets 0x24, 0x28, 0x30 and 0x34 ignore writes; 0x38 and every unmapped offset read as 0.
- R11: Control bits held without a commit change neither the base nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset for read and write |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Combinational read data at bus_addr |
| commit | input | 1 | One-cycle pulse that carries out the selected operations |
| time_sec | output | 32 | Current time in seconds: base plus counter |

## Verification
The assertions assume that `commit` is a clean one-cycle pulse in the clock domain. They also assume that the control bits are not changed in the cycle a commit is sampled, so the operation set is the one that was written before the pulse. The bench always writes the control register on an earlier cycle than the commit, drops `commit` after a single cycle, and changes inputs only on falling edges. It never combines a trigger write with an arming commit in the same cycle.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    // Register byte offsets
    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_ARM    = 'h04;
    localparam int OFF_WLO    = 'h10;
    localparam int OFF_WHI    = 'h14;
    localparam int OFF_RLO    = 'h24;
    localparam int OFF_RHI    = 'h28;
    localparam int OFF_SLO    = 'h30;
    localparam int OFF_SHI    = 'h34;
    localparam int OFF_TRIG   = 'h38;

    // Control bit positions
    localparam int CB_BASE_WR = 1;
    localparam int CB_BASE_RD = 2;
    localparam int CB_CNT_CLR = 3;
    localparam int CB_F0_WR   = 5;
    localparam int CB_F1_WR   = 6;
    localparam int CB_F0_RD   = 7;
    localparam int CB_F1_RD   = 8;

    typedef enum logic [0:0] {
        SNAP_IDLE  = 1'b0,
        SNAP_ARMED = 1'b1
    } snap_state_e;

    typedef struct packed {
        logic base_wr;
        logic base_rd;
        logic cnt_clr;
        logic f0_wr;
        logic f1_wr;
        logic f0_rd;
        logic f1_rd;
        logic cnt_arm;
    } commit_ops_t;

endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_core_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [HALF_W-1:0]   bus_wdata,
    input  logic                commit,
    output logic [HALF_W-1:0]   ctrl_o,
    output logic                arm_req_o,
    output logic [WORD_W-1:0]   wdata_o,
    output commit_ops_t         ops_o,
    output logic                trig_o
);

    logic [HALF_W-1:0] ctrl_q;
    logic              arm_q;
    logic [HALF_W-1:0] wlo_q;
    logic [HALF_W-1:0] whi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            arm_q  <= 1'b0;
            wlo_q  <= '0;
            whi_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFF_CTRL)) ctrl_q <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_ARM))  arm_q  <= bus_wdata[0];
            if (bus_addr == ADDR_W'(OFF_WLO))  wlo_q  <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_WHI))  whi_q  <= bus_wdata;
        end
    end

    always_comb begin
        ops_o = '0;
        if (commit) begin
            ops_o.base_wr = ctrl_q[CB_BASE_WR];
            ops_o.base_rd = ctrl_q[CB_BASE_RD];
            ops_o.cnt_clr = ctrl_q[CB_CNT_CLR];
            ops_o.f0_wr   = ctrl_q[CB_F0_WR];
            ops_o.f1_wr   = ctrl_q[CB_F1_WR];
            ops_o.f0_rd   = ctrl_q[CB_F0_RD];
            ops_o.f1_rd   = ctrl_q[CB_F1_RD];
            ops_o.cnt_arm = arm_q;
        end
    end

    assign trig_o    = bus_wr && (bus_addr == ADDR_W'(OFF_TRIG)) && bus_wdata[0];
    assign ctrl_o    = ctrl_q;
    assign arm_req_o = arm_q;
    assign wdata_o   = {whi_q, wlo_q};

endmodule

// File: rtl/rtc_value_store.sv
module rtc_value_store
    import rtc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  commit_ops_t       ops_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] base_o,
    output logic [WORD_W-1:0] rdata_o
);

    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] flag0_q;
    logic [WORD_W-1:0] flag1_q;
    logic [WORD_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            flag0_q <= '0;
            flag1_q <= '0;
            rdata_q <= '0;
        end else begin
            if (ops_i.base_wr) base_q  <= wdata_i;
            if (ops_i.f0_wr)   flag0_q <= wdata_i;
            if (ops_i.f1_wr)   flag1_q <= wdata_i;
            // Read priority: base, then flag 0, then flag 1; pre-commit values
            if (ops_i.base_rd)    rdata_q <= base_q;
            else if (ops_i.f0_rd) rdata_q <= flag0_q;
            else if (ops_i.f1_rd) rdata_q <= flag1_q;
        end
    end

    assign base_o  = base_q;
    assign rdata_o = rdata_q;

    // R3 / R11: base moves only on a committed base write
    p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ops_i.base_wr |=> $stable(base_q));

    // R7: flags move only on their committed write
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ops_i.f0_wr || ops_i.f1_wr) |=> ($stable(flag0_q) && $stable(flag1_q)));

    // R8: read data moves only on a committed read
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ops_i.base_rd || ops_i.f0_rd || ops_i.f1_rd) |=> $stable(rdata_q));

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_core_pkg::*;
#(
    parameter int TICK_DIV = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              arm_i,
    input  logic              trig_i,
    output logic [WORD_W-1:0] cnt_o,
    output logic [WORD_W-1:0] snap_o
);

    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0]  div_q;
    logic [WORD_W-1:0] cnt_q;
    logic [WORD_W-1:0] snap_q;
    snap_state_e       state_q, state_d;
    logic              take_snap;

    // Divider and seconds counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (clr_i) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Snapshot state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SNAP_IDLE;
        else        state_q <= state_d;
    end

    // Snapshot next state and output
    always_comb begin
        state_d   = state_q;
        take_snap = 1'b0;
        unique case (state_q)
            SNAP_IDLE: begin
                if (arm_i) state_d = SNAP_ARMED;
            end
            SNAP_ARMED: begin
                if (trig_i) begin
                    take_snap = 1'b1;
                    if (!arm_i) state_d = SNAP_IDLE;
                end
            end
            default: state_d = SNAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         snap_q <= '0;
        else if (take_snap) snap_q <= cnt_q;
    end

    assign cnt_o  = cnt_q;
    assign snap_o = snap_q;

    // R5: counter never jumps by more than one second per cycle
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    // R4: a clear leaves the counter at zero
    p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

    // R9: snapshot holds unless armed and triggered
    p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == SNAP_ARMED && trig_i) |=> $stable(snap_q));

endmodule

// File: rtl/rtc_base_counter_core.sv
module rtc_base_counter_core
    import rtc_core_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int TICK_DIV = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              commit,
    output logic [31:0]       time_sec
);

    logic [HALF_W-1:0] ctrl;
    logic              arm_req;
    logic [WORD_W-1:0] wdata;
    commit_ops_t       ops;
    logic              trig;
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] rdata;
    logic [WORD_W-1:0] cnt;
    logic [WORD_W-1:0] snap;

    rtc_ctrl_regs #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .commit    (commit),
        .ctrl_o    (ctrl),
        .arm_req_o (arm_req),
        .wdata_o   (wdata),
        .ops_o     (ops),
        .trig_o    (trig)
    );

    rtc_value_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ops_i   (ops),
        .wdata_i (wdata),
        .base_o  (base),
        .rdata_o (rdata)
    );

    rtc_sec_counter #(.TICK_DIV(TICK_DIV)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ops.cnt_clr),
        .arm_i  (ops.cnt_arm),
        .trig_i (trig),
        .cnt_o  (cnt),
        .snap_o (snap)
    );

    assign time_sec = base + cnt;

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFF_CTRL): bus_rdata = ctrl;
            ADDR_W'(OFF_ARM):  bus_rdata = {{(HALF_W-1){1'b0}}, arm_req};
            ADDR_W'(OFF_WLO):  bus_rdata = wdata[HALF_W-1:0];
            ADDR_W'(OFF_WHI):  bus_rdata = wdata[WORD_W-1:HALF_W];
            ADDR_W'(OFF_RLO):  bus_rdata = rdata[HALF_W-1:0];
            ADDR_W'(OFF_RHI):  bus_rdata = rdata[WORD_W-1:HALF_W];
            ADDR_W'(OFF_SLO):  bus_rdata = snap[HALF_W-1:0];
            ADDR_W'(OFF_SHI):  bus_rdata = snap[WORD_W-1:HALF_W];
            default:           bus_rdata = '0;
        endcase
    end

    // R11: with no commit, the reported time moves by at most one second
    p_no_commit_jump_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (time_sec == $past(time_sec) || time_sec == $past(time_sec) + 1'b1));

endmodule

// File: tb/tb_rtc_base_counter_core.sv
module tb_rtc_base_counter_core;

    localparam int TD = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        commit = 1'b0;
    logic [31:0] time_sec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rtc_base_counter_core #(.ADDR_W(8), .TICK_DIV(TD)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .commit(commit),
        .time_sec(time_sec)
    );

    // addr, write data, expected readback
    localparam logic [39:0] VEC [8] = '{
        {8'h00, 16'h01AB, 16'h01AB},
        {8'h04, 16'hFFFF, 16'h0001},
        {8'h10, 16'hABCD, 16'hABCD},
        {8'h14, 16'h1234, 16'h1234},
        {8'h24, 16'hFFFF, 16'h0000},
        {8'h30, 16'hFFFF, 16'h0000},
        {8'h38, 16'h0001, 16'h0000},
        {8'h3C, 16'h5555, 16'h0000}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rd32(input logic [7:0] lo, output logic [31:0] v);
        logic [15:0] l, h;
        rd(lo, l);
        rd(lo + 8'h04, h);
        v = {h, l};
    endtask

    task automatic do_commit();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic wr32(input logic [31:0] d);
        wr(8'h10, d[15:0]);
        wr(8'h14, d[31:16]);
    endtask

    task automatic op(input logic [15:0] ctrl);
        wr(8'h00, ctrl);
        do_commit();
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [15:0] v;
        logic [31:0] v32;
        logic [31:0] exp_snap;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 time", time_sec, 32'h0);
        foreach (VEC[i]) begin
            rd(VEC[i][39:32], v);
            check("R1 reg", {16'h0, v}, 32'h0);
        end

        // R2 / R10: register map walk
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][39:32], VEC[i][31:16]);
            rd(VEC[i][39:32], v);
            check("R2/R10 readback", {16'h0, v}, {16'h0, VEC[i][15:0]});
        end

        // R11: control held without commit (base_wr and cnt_clr set)
        repeat (3) @(negedge clk);
        check("R11 base untouched", {31'h0, time_sec < 32'd100}, 32'h1);
        wr(8'h04, 16'h0000);

        // R1: flag 0 reads 0 after reset
        op(16'h0080);
        rd32(8'h24, v32);
        check("R1 flag0 invalid", v32, 32'h0);

        // R3 / R4: set base then clear counter
        wr32(32'h12345678);
        op(16'h0002);
        op(16'h0008);
        check("R3/R4 time after clear", time_sec, 32'h12345678);
        repeat (TD - 1) @(negedge clk);
        check("R4 no early tick", time_sec, 32'h12345678);
        @(negedge clk);
        check("R5 first tick", time_sec, 32'h12345679);
        repeat (2 * TD) @(negedge clk);
        check("R5 steady rate", time_sec, 32'h1234567B);

        // R7 / R8: flags and read priority
        wr32(32'h00000001);
        op(16'h0020);
        wr32(32'hBEEF0042);
        op(16'h0040);
        op(16'h0080);
        rd32(8'h24, v32);
        check("R7 flag0 valid", v32, 32'h1);
        op(16'h0180);
        rd32(8'h24, v32);
        check("R8 flag0 over flag1", v32, 32'h1);
        op(16'h0100);
        rd32(8'h24, v32);
        check("R7 flag1", v32, 32'hBEEF0042);
        op(16'h0184);
        rd32(8'h24, v32);
        check("R8 base first", v32, 32'h12345678);

        // R8 / R6: read returns pre-commit base; wrap of sum
        wr32(32'hFFFFFFFF);
        op(16'h000E);
        rd32(8'h24, v32);
        check("R8 old base", v32, 32'h12345678);
        check("R6 new base", time_sec, 32'hFFFFFFFF);
        repeat (TD) @(negedge clk);
        check("R6 wrap", time_sec, 32'h0);

        // R9: trigger while idle is ignored
        wr(8'h38, 16'h0001);
        rd32(8'h30, v32);
        check("R9 unarmed trigger", v32, 32'h0);

        // R9: arm then trigger
        wr(8'h00, 16'h0000);
        wr(8'h04, 16'h0001);
        do_commit();
        wr(8'h04, 16'h0000);
        repeat (7) @(negedge clk);
        exp_snap = time_sec - 32'hFFFFFFFF;
        wr(8'h38, 16'h0001);
        rd32(8'h30, v32);
        check("R9 snapshot", v32, exp_snap);

        // R9: second trigger after disarm leaves snapshot
        repeat (2 * TD) @(negedge clk);
        wr(8'h38, 16'h0001);
        rd32(8'h30, v32);
        check("R9 disarmed", v32, exp_snap);

        report();
    end

endmodule